// File: doc/BRIEF.md
# Counted SPI transmit engine

This block is a transmit-only SPI master. Software, or a DMA-free register front end, pushes 32-bit words into an output FIFO. Each word carries one to four bytes packed least significant byte first. The engine shifts a programmed number of words out on the serial lines, most significant bit first. A separate sequencing controller drives two plain inputs:

- a clear strobe, which loads the configuration and the word count, flushes the FIFO and aborts any word in flight;
- a run level, which lets new words begin.

The receive path is absent by design.

The clear strobe latches the following settings:
- word length, written as bits per word minus one;
- serial clock idle level;
- chip-select polarity;
- output drive policy;
- clock divider.

These settings stay fixed until the next clear. A status vector reports FIFO occupancy, a refill request and completion. A down-counter gives the number of words still to send. A one-cycle error pulse flags a write that arrived while the FIFO was full.

Top module: `spi_tx_engine`

## Requirements
- R1: The latched word-length field `cfg_bits_m1` makes every SPI word `cfg_bits_m1`+1 bits long. The values 7, 15, 23 and 31 select 1, 2, 3 or 4 bytes. Only bits `cfg_bits_m1`..0 of a FIFO word are sent.
- R2: Byte k of a FIFO word sits in bits 8k+7..8k. Within a word the first bit on `spi_mosi` is bit `cfg_bits_m1` and the last is bit 0.
- R3: A clear loads `cfg_out_count` into `remaining_cnt`. Exactly that many words are sent. `remaining_cnt` drops by one as each word completes. A count of zero sends nothing.
- R4: `op_status` has these bits, and all other bits are 0:
  - bit 4 = FIFO not empty;
  - bit 6 = FIFO full;
  - bit 8 = refill request (words remain to send and the FIFO holds fewer than half its depth);
  - bit 10 = done (`remaining_cnt` is zero).
- R5: `spi_sclk` rests at the latched idle level. Each bit is placed on `spi_mosi` while the clock is idle and is held through the leading edge, which is the edge away from idle.
- R6: Each clock half-period lasts `cfg_clk_div`+1 core cycles. The divider is latched at clear, so a change during a run has no effect.
- R7: Chip select is active high when `cfg_cs_high`=1, otherwise active low. It asserts at the start of the first word and stays asserted through FIFO gaps and pauses until the count reaches zero.
- R8: `spi_oe` is 1 at all times when `cfg_drive_all`=1. Otherwise it is 1 only while chip select is asserted.
- R9: While `ctl_run` is low no new word begins and `remaining_cnt` holds.
- R10: A write into a full FIFO is dropped, leaving the FIFO contents unchanged. `err_overrun` is 1 for one cycle after that write.
- R11: During reset `spi_sclk`=0, `spi_cs`=1, `spi_oe`=0, `op_status`=0x400 and `remaining_cnt`=0.
- R12: A clear empties the FIFO and aborts a word in flight. Chip select deasserts and the clock returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_clear | input | 1 | Clear strobe: latch config and count, flush FIFO, abort |
| ctl_run | input | 1 | Allows new words to start |
| cfg_bits_m1 | input | 5 | Bits per word minus one |
| cfg_out_count | input | CW | Words to send per run |
| cfg_clk_div | input | DIVW | Half-period minus one, in core cycles |
| cfg_idle_high | input | 1 | Serial clock idles high |
| cfg_cs_high | input | 1 | Chip select active high |
| cfg_drive_all | input | 1 | Drive outputs even when deselected |
| fifo_wr_en | input | 1 | FIFO write strobe |
| fifo_wr_data | input | 32 | FIFO write word |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_cs | output | 1 | Chip select |
| spi_oe | output | 1 | Output driver enable |
| op_status | output | 12 | Status vector |
| remaining_cnt | output | CW | Words still to send |
| err_overrun | output | 1 | Dropped-write pulse |

## Verification
The hardest states to reach are the ones where chip select must stay asserted while nothing is shifting. The first is a FIFO that runs dry partway through the count. The second is a run level that drops exactly at a word boundary.

The bench reaches both deliberately. It pushes fewer words than the programmed count. It then watches `remaining_cnt` at falling edges and lowers `ctl_run` in the very cycle the count steps, before the engine can start the next word. While the engine is paused there, the bench also changes the divider, which shows that the latched divider keeps the clock half-periods unchanged.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  localparam int WORD_W = 32;
  localparam int BITS_W = $clog2(WORD_W);

  localparam int ST_NOT_EMPTY = 4;
  localparam int ST_FULL      = 6;
  localparam int ST_SERVICE   = 8;
  localparam int ST_DONE      = 10;
  localparam int ST_W         = 12;

  typedef struct packed {
    logic [BITS_W-1:0] bits_m1;
    logic              idle_high;
    logic              cs_high;
    logic              drive_all;
  } tx_cfg_t;
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic            full,
  output logic            not_empty,
  output logic [$clog2(DEPTH):0] level,
  output logic            overrun
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic          push, pop;

  assign level     = wp - rp;
  assign full      = (level == (AW+1)'(DEPTH));
  assign not_empty = (level != '0);
  assign push      = wr_en && !full && !flush;
  assign pop       = rd_en && not_empty && !flush;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop) rd_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp      <= '0;
      rp      <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      overrun <= wr_en && full;
    end
  end

  // R4
  fifo_level_chk: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  // R10
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !flush && !rd_en) |=> (level == (AW+1)'(DEPTH)));
endmodule

// File: rtl/spi_tx_wordcnt.sv
module spi_tx_wordcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] remaining,
  output logic          zero
);
  always_ff @(posedge clk) begin
    if (rst)       remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec)  remaining <= remaining - 1'b1;
  end

  assign zero = (remaining == '0);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int DIVW = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          abort,
  input  logic                          run,
  input  logic                          words_left,
  input  logic                          fifo_avail,
  input  logic [spi_tx_pkg::BITS_W-1:0] bits_m1,
  input  logic                          idle_high,
  input  logic [DIVW-1:0]               div,
  input  logic [spi_tx_pkg::WORD_W-1:0] fifo_rd_data,
  output logic                          fifo_pop,
  output logic                          word_done,
  output logic                          sclk,
  output logic                          mosi
);
  import spi_tx_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} sh_state_t;
  localparam logic [BITS_W-1:0] TOP_BIT = BITS_W'(WORD_W-1);

  sh_state_t         state;
  logic [WORD_W-1:0] shreg;
  logic [BITS_W-1:0] bitcnt;
  logic [DIVW-1:0]   timer;
  logic              phase;
  logic              tick;

  assign tick      = (timer == div);
  assign fifo_pop  = (state == S_IDLE) && !abort && run && words_left && fifo_avail;
  assign word_done = (state == S_SHIFT) && !abort && tick && phase && (bitcnt == '0);
  assign mosi      = shreg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      shreg  <= '0;
      bitcnt <= '0;
      timer  <= '0;
      phase  <= 1'b0;
      sclk   <= 1'b0;
    end else if (abort) begin
      state  <= S_IDLE;
      shreg  <= '0;
      phase  <= 1'b0;
      timer  <= '0;
      sclk   <= idle_high;
    end else begin
      unique case (state)
        S_IDLE: begin
          sclk <= idle_high;
          if (fifo_pop) state <= S_LOAD;
        end
        S_LOAD: begin
          shreg  <= fifo_rd_data << (TOP_BIT - bits_m1);
          bitcnt <= bits_m1;
          timer  <= '0;
          phase  <= 1'b0;
          state  <= S_SHIFT;
        end
        S_SHIFT: begin
          if (tick) begin
            timer <= '0;
            if (!phase) begin
              phase <= 1'b1;
              sclk  <= !idle_high;
            end else begin
              phase <= 1'b0;
              sclk  <= idle_high;
              if (bitcnt == '0) begin
                state <= S_IDLE;
              end else begin
                shreg  <= shreg << 1;
                bitcnt <= bitcnt - 1'b1;
              end
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_SHIFT && phase && $past(state == S_SHIFT && phase) && !$past(abort))
      |-> $stable(mosi));

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && $past(state == S_IDLE) && !$past(abort) && !$past(rst))
      |-> (sclk == idle_high));
endmodule

// File: rtl/spi_tx_engine.sv
module spi_tx_engine #(
  parameter int FIFO_DEPTH = 8,
  parameter int CW         = 16,
  parameter int DIVW       = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_clear,
  input  logic            ctl_run,
  input  logic [4:0]      cfg_bits_m1,
  input  logic [CW-1:0]   cfg_out_count,
  input  logic [DIVW-1:0] cfg_clk_div,
  input  logic            cfg_idle_high,
  input  logic            cfg_cs_high,
  input  logic            cfg_drive_all,
  input  logic            fifo_wr_en,
  input  logic [31:0]     fifo_wr_data,
  output logic            spi_sclk,
  output logic            spi_mosi,
  output logic            spi_cs,
  output logic            spi_oe,
  output logic [11:0]     op_status,
  output logic [CW-1:0]   remaining_cnt,
  output logic            err_overrun
);
  import spi_tx_pkg::*;

  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  tx_cfg_t           cfg_q, cfg_nxt;
  logic [DIVW-1:0]   div_q;
  logic [WORD_W-1:0] rd_data;
  logic              fifo_full, fifo_ne, fifo_pop, word_done, cnt_zero;
  logic [LW-1:0]     fifo_level;
  logic              cs_act, cs_act_nxt;

  assign cfg_nxt = ctl_clear ? '{bits_m1: cfg_bits_m1, idle_high: cfg_idle_high,
                                 cs_high: cfg_cs_high, drive_all: cfg_drive_all}
                             : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{bits_m1: 5'd7, idle_high: 1'b0, cs_high: 1'b0, drive_all: 1'b0};
      div_q <= '0;
    end else if (ctl_clear) begin
      cfg_q <= cfg_nxt;
      div_q <= cfg_clk_div;
    end
  end

  spi_tx_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(ctl_clear),
    .wr_en(fifo_wr_en), .wr_data(fifo_wr_data), .rd_en(fifo_pop),
    .rd_data(rd_data), .full(fifo_full), .not_empty(fifo_ne),
    .level(fifo_level), .overrun(err_overrun)
  );

  spi_tx_wordcnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(ctl_clear), .load_val(cfg_out_count),
    .dec(word_done), .remaining(remaining_cnt), .zero(cnt_zero)
  );

  spi_tx_shifter #(.DIVW(DIVW)) u_shift (
    .clk(clk), .rst(rst), .abort(ctl_clear), .run(ctl_run),
    .words_left(!cnt_zero), .fifo_avail(fifo_ne),
    .bits_m1(cfg_q.bits_m1), .idle_high(cfg_q.idle_high), .div(div_q),
    .fifo_rd_data(rd_data), .fifo_pop(fifo_pop), .word_done(word_done),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );

  always_comb begin
    cs_act_nxt = cs_act;
    if (ctl_clear)                                          cs_act_nxt = 1'b0;
    else if (fifo_pop)                                      cs_act_nxt = 1'b1;
    else if (word_done && remaining_cnt == CW'(1))          cs_act_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_act <= 1'b0;
      spi_cs <= 1'b1;
      spi_oe <= 1'b0;
    end else begin
      cs_act <= cs_act_nxt;
      spi_cs <= cs_act_nxt ? cfg_nxt.cs_high : !cfg_nxt.cs_high;
      spi_oe <= cfg_nxt.drive_all || cs_act_nxt;
    end
  end

  always_comb begin
    op_status               = '0;
    op_status[ST_NOT_EMPTY] = fifo_ne;
    op_status[ST_FULL]      = fifo_full;
    op_status[ST_SERVICE]   = !cnt_zero && (fifo_level < LW'(FIFO_DEPTH / 2));
    op_status[ST_DONE]      = cnt_zero;
  end

  // R7
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_zero |-> !cs_act);

  // R9
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_run && !ctl_clear && !cs_act) |=> $stable(remaining_cnt));
endmodule

// File: tb/spi_tx_engine_tb.sv
module spi_tx_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_clear = 1'b0, ctl_run = 1'b0;
  logic [4:0]  cfg_bits_m1 = 5'd7;
  logic [15:0] cfg_out_count = '0;
  logic [7:0]  cfg_clk_div = '0;
  logic        cfg_idle_high = 1'b0, cfg_cs_high = 1'b0, cfg_drive_all = 1'b0;
  logic        fifo_wr_en = 1'b0;
  logic [31:0] fifo_wr_data = '0;
  logic        spi_sclk, spi_mosi, spi_cs, spi_oe, err_overrun;
  logic [11:0] op_status;
  logic [15:0] remaining_cnt;

  always #5 clk = ~clk;

  spi_tx_engine u_dut (
    .clk(clk), .rst(rst), .ctl_clear(ctl_clear), .ctl_run(ctl_run),
    .cfg_bits_m1(cfg_bits_m1), .cfg_out_count(cfg_out_count), .cfg_clk_div(cfg_clk_div),
    .cfg_idle_high(cfg_idle_high), .cfg_cs_high(cfg_cs_high), .cfg_drive_all(cfg_drive_all),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs(spi_cs), .spi_oe(spi_oe),
    .op_status(op_status), .remaining_cnt(remaining_cnt), .err_overrun(err_overrun)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, lead_t = 0, nb = 0, rx_n = 0;
  int cs_err = 0, oe_err = 0, dur_err = 0;
  logic [31:0] acc = '0;
  logic [31:0] rx [32];
  logic [31:0] sent [16];
  logic        mon_en = 1'b0, prev_sclk = 1'b0;
  int          exp_bits = 7, exp_div = 0;
  logic        exp_idle = 1'b0, exp_csh = 1'b0;
  logic        last_ovr = 1'b0;

  // receiver model: sample on the edge leaving idle
  always @(negedge clk) begin
    if (mon_en && spi_sclk !== prev_sclk) begin
      if (prev_sclk == exp_idle) begin
        acc = {acc[30:0], spi_mosi};
        nb++;
        lead_t = cyc;
        if (spi_cs !== exp_csh) cs_err++;
        if (spi_oe !== 1'b1) oe_err++;
        if (nb == exp_bits + 1) begin
          if (rx_n < 32) rx[rx_n] = acc;
          rx_n++;
          nb = 0;
          acc = '0;
        end
      end else if (cyc - lead_t != exp_div + 1) begin
        dur_err++;
      end
    end
    prev_sclk = spi_sclk;
    cyc++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int bits_m1);
    return (bits_m1 == 31) ? 32'hFFFF_FFFF : ((32'h1 << (bits_m1 + 1)) - 32'h1);
  endfunction

  task automatic do_clear(input int bits_m1, input int count, input logic idle,
                          input logic csh, input logic drv, input int div);
    mon_en = 1'b0;
    @(negedge clk);
    cfg_bits_m1 = 5'(bits_m1); cfg_out_count = 16'(count); cfg_clk_div = 8'(div);
    cfg_idle_high = idle; cfg_cs_high = csh; cfg_drive_all = drv;
    exp_bits = bits_m1; exp_div = div; exp_idle = idle; exp_csh = csh;
    ctl_clear = 1'b1;
    @(negedge clk);
    ctl_clear = 1'b0;
    @(negedge clk);
    @(negedge clk);
    nb = 0; acc = '0; rx_n = 0;
    mon_en = 1'b1;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    fifo_wr_en = 1'b1; fifo_wr_data = w;
    @(negedge clk);
    fifo_wr_en = 1'b0;
    last_ovr = err_overrun;
  endtask

  task automatic wait_done(input string req);
    int i;
    for (i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (op_status[10] === 1'b1) break;
    end
    chk(req, 32'(op_status[10]), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 sclk", 32'(spi_sclk), 32'd0);
    chk("R11 cs", 32'(spi_cs), 32'd1);
    chk("R11 oe", 32'(spi_oe), 32'd0);
    chk("R11 status", 32'(op_status), 32'h400);
    chk("R11 remaining", 32'(remaining_cnt), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R5 R7 R8 sweep over word length, polarities and divider
    ctl_run = 1'b1;
    for (int b = 0; b < 4; b++)
      for (int idle = 0; idle < 2; idle++)
        for (int csh = 0; csh < 2; csh++)
          for (int d = 0; d < 2; d++) begin
            int bits;
            logic drv;
            bits = 8 * b + 7;
            drv  = 1'(idle ^ csh);
            do_clear(bits, 3, 1'(idle), 1'(csh), drv, 2 * d);
            chk("R7 cs idle before run", 32'(spi_cs), 32'(!csh));
            for (int k = 0; k < 3; k++) begin
              sent[k] = 32'hA5C3_0F69 ^ (32'(b * 16 + idle * 8 + csh * 4 + d) * 32'h0101_0101)
                        ^ (32'(k) << 11);
              push(sent[k]);
            end
            wait_done("R3 done");
            @(negedge clk);
            chk("R3 word count", 32'(rx_n), 32'd3);
            for (int k = 0; k < 3; k++)
              chk("R1 R2 word data", rx[k], sent[k] & mask_of(bits));
            chk("R4 status after run", 32'(op_status), 32'h400);
            chk("R7 cs released", 32'(spi_cs), 32'(!csh));
            chk("R5 sclk idle", 32'(spi_sclk), 32'(idle));
            chk("R8 oe idle", 32'(spi_oe), 32'(drv));
          end
    chk("R7 cs asserted at every bit", 32'(cs_err), 32'd0);
    chk("R8 oe during transfer", 32'(oe_err), 32'd0);
    chk("R6 half period", 32'(dur_err), 32'd0);

    // R4 R10 status bits and dropped write into a full FIFO
    ctl_run = 1'b0;
    do_clear(31, 8, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 service request", 32'(op_status), 32'h100);
    for (int k = 0; k < 4; k++) begin sent[k] = 32'h1000_0001 * 32'(k + 1); push(sent[k]); end
    chk("R4 half full", 32'(op_status), 32'h010);
    for (int k = 4; k < 8; k++) begin sent[k] = 32'h1000_0001 * 32'(k + 1); push(sent[k]); end
    chk("R4 full", 32'(op_status), 32'h050);
    chk("R10 no pulse on accepted write", 32'(last_ovr), 32'd0);
    push(32'hDEAD_BEEF);
    chk("R10 overrun pulse", 32'(last_ovr), 32'd1);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(err_overrun), 32'd0);
    ctl_run = 1'b1;
    wait_done("R3 done full run");
    @(negedge clk);
    chk("R10 eight words", 32'(rx_n), 32'd8);
    for (int k = 0; k < 8; k++) chk("R10 kept contents", rx[k], sent[k]);
    chk("R10 dropped word absent", 32'(op_status), 32'h400);

    // R7 R9 R6 FIFO gap, pause at a word boundary, divider change ignored
    do_clear(7, 4, 1'b1, 1'b1, 1'b0, 1);
    sent[0] = 32'h0000_00C5; sent[1] = 32'h0000_0033;
    push(sent[0]); push(sent[1]);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (remaining_cnt == 16'd2) break;
    end
    ctl_run = 1'b0;
    repeat (100) @(negedge clk);
    chk("R7 cs held in gap", 32'(spi_cs), 32'd1);
    chk("R5 sclk idle in gap", 32'(spi_sclk), 32'd1);
    chk("R3 remaining in gap", 32'(remaining_cnt), 32'd2);
    sent[2] = 32'h0000_00F0; sent[3] = 32'h0000_0081;
    push(sent[2]); push(sent[3]);
    cfg_clk_div = 8'd5;
    repeat (100) @(negedge clk);
    chk("R9 paused remaining", 32'(remaining_cnt), 32'd2);
    chk("R9 paused words", 32'(rx_n), 32'd2);
    chk("R7 cs held while paused", 32'(spi_cs), 32'd1);
    ctl_run = 1'b1;
    wait_done("R9 resumes");
    @(negedge clk);
    for (int k = 0; k < 4; k++) chk("R2 gap run data", rx[k], sent[k]);
    chk("R6 latched divider", 32'(dur_err), 32'd0);
    chk("R7 cs after gap run", 32'(spi_cs), 32'd0);

    // R3 zero count sends nothing
    do_clear(15, 0, 1'b0, 1'b0, 1'b1, 0);
    push(32'h0000_1234); push(32'h0000_5678);
    repeat (200) @(negedge clk);
    chk("R3 zero count words", 32'(rx_n), 32'd0);
    chk("R3 zero count status", 32'(op_status), 32'h410);
    chk("R8 drive all", 32'(spi_oe), 32'd1);

    // R12 clear aborts a word and flushes
    do_clear(31, 2, 1'b0, 1'b0, 1'b0, 3);
    push(32'hFFFF_0000); push(32'h0000_FFFF);
    repeat (20) @(negedge clk);
    chk("R12 cs active mid word", 32'(spi_cs), 32'd0);
    do_clear(31, 0, 1'b0, 1'b0, 1'b0, 3);
    chk("R12 flushed", 32'(op_status), 32'h400);
    chk("R12 cs released", 32'(spi_cs), 32'd1);
    chk("R12 sclk idle", 32'(spi_sclk), 32'd0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule